// File: doc/BRIEF.md
# Memory Request Packet Builder (32-bit addressing)

This block turns one command into a PCIe memory request packet with 32-bit addressing and sends it out as a stream of 32-bit dwords. A command holds a direction flag (write or read), a requester ID, a tag, a target address and a length in dwords. For writes, the payload dwords come from a separate write-data stream. The block builds the three-dword header itself: format and type, length, byte enables, requester ID, tag and address.

The output stream uses valid/ready flow control and has start and end markers. For a write, the payload follows the last header dword with no gap and no filler dwords, so the packet is exactly three header dwords plus the stated number of data dwords. For a read, the packet is the header alone.

The block accepts a new command only when it is idle. One command is in flight at a time.

Top module: `tlp_mem_req_builder`

## Requirements
- R1: While reset is asserted and just after it, `cmd_ready` is 1 and `tx_valid` is 0.
- R2: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from that point until the final dword of the packet is handed off. It is 1 again in the cycle after that handoff. Command inputs that change while the block is busy have no effect on the packet.
- R3: Header dword 0 holds the format/type byte in bits 31:24 (0x40 for a write, 0x00 for a read). Bits 23:10 are zero. Bits 9:0 hold the command length, where 0 means 1024 dwords.
- R4: Header dword 1 holds the requester ID in bits 31:16, the tag in bits 15:8, the last-dword byte enable in bits 7:4 and the first-dword byte enable in bits 3:0. The first enable is always 0xF. The last enable is 0x0 for a one-dword length and 0xF otherwise.
- R5: Header dword 2 is the command address with bits 1:0 forced to zero.
- R6: For a write, the payload dwords follow header dword 2 directly. Exactly the encoded number of them is sent, in the order they arrive on `wdat_data`, with no filler dwords. `wdat_ready` equals `tx_ready` during the payload and is 0 at all other times.
- R7: For a read, the packet ends with header dword 2 (end marker set on it). `wdat_ready` stays 0 for the whole packet.
- R8: `tx_sop` is 1 only on header dword 0. `tx_eop` is 1 only on the final dword of the packet.
- R9: While the header is being sent, `tx_valid` is 1 and the output is held steady until `tx_ready` is seen. During the payload, `tx_valid` follows `wdat_valid`.
- R10: In the cycle after a command is taken, `tx_valid` and `tx_sop` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Builder idle, command can be taken |
| cmd_write | input | 1 | 1 = memory write, 0 = memory read |
| cmd_req_id | input | 16 | Requester ID |
| cmd_tag | input | 8 | Transaction tag |
| cmd_addr | input | 32 | Target byte address (bits 1:0 ignored) |
| cmd_len | input | 10 | Length in dwords, 0 encodes 1024 |
| wdat_valid | input | 1 | Write payload dword offered |
| wdat_ready | output | 1 | Write payload dword taken |
| wdat_data | input | 32 | Write payload dword |
| tx_valid | output | 1 | Output dword valid |
| tx_ready | input | 1 | Downstream accepts output dword |
| tx_data | output | 32 | Output dword |
| tx_sop | output | 1 | First dword of packet |
| tx_eop | output | 1 | Last dword of packet |

## Verification
The hold property on the output assumes that the write-data source keeps `wdat_valid` high and `wdat_data` unchanged once it has offered a dword, until `wdat_ready` takes it. The bench enforces this by latching its offer flag and clearing it only on a handshake. The checks also assume that commands are never offered while reset is asserted. The stimulus keeps `cmd_valid` high with scrambled fields during each packet, then drops it in the cycle the block returns to idle. This means no unintended command is ever taken, while the "ignored while busy" rule is still exercised.

// File: rtl/tlp_req_pkg.sv
`timescale 1ns/1ps
package tlp_req_pkg;

   localparam int DW_W        = 32;
   localparam int HDR_DWORDS  = 3;
   localparam int FT_W        = 8;
   localparam int BE_W        = 4;

   localparam logic [FT_W-1:0] FT_MEM_WR32 = 8'h40;
   localparam logic [FT_W-1:0] FT_MEM_RD32 = 8'h00;
   localparam logic [BE_W-1:0] BE_ALL      = 4'hF;
   localparam logic [BE_W-1:0] BE_NONE     = 4'h0;

   typedef logic [DW_W-1:0] dword_t;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_HDR0 = 3'd1,
      SQ_HDR1 = 3'd2,
      SQ_HDR2 = 3'd3,
      SQ_DATA = 3'd4
   } sq_state_e;

endpackage

// File: rtl/tlp_hdr_reg.sv
`timescale 1ns/1ps
module tlp_hdr_reg
   import tlp_req_pkg::*;
#(
   parameter int ID_W  = 16,
   parameter int TAG_W = 8,
   parameter int LEN_W = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load,
   input  logic                            wr,
   input  logic [ID_W-1:0]                 req_id,
   input  logic [TAG_W-1:0]                tag,
   input  logic [DW_W-1:0]                 addr,
   input  logic [LEN_W-1:0]                len,
   output logic [HDR_DWORDS-1:0][DW_W-1:0] hdr_q,
   output logic                            wr_q
);

   localparam int LENF_W = DW_W - FT_W;
   localparam int DW1_W  = ID_W + TAG_W + 2 * BE_W;

   generate
      if (DW1_W != DW_W) begin : g_bad_dw1
         $error("tlp_hdr_reg: ID_W + TAG_W must leave exactly two byte-enable nibbles");
      end
      if (LEN_W != 10) begin : g_bad_len
         $error("tlp_hdr_reg: length field must be 10 bits");
      end
   endgenerate

   logic [HDR_DWORDS-1:0][DW_W-1:0] hdr_d;
   logic                            one_dw;
   logic [LENF_W-1:0]               len_field;

   always_comb begin
      one_dw    = (len == LEN_W'(1));
      len_field = LENF_W'(len);
      hdr_d[0]  = {(wr ? FT_MEM_WR32 : FT_MEM_RD32), len_field};
      hdr_d[1]  = {req_id, tag, (one_dw ? BE_NONE : BE_ALL), BE_ALL};
      hdr_d[2]  = addr & ~dword_t'(3);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_q <= '0;
         wr_q  <= 1'b0;
      end else if (load) begin
         hdr_q <= hdr_d;
         wr_q  <= wr;
      end
   end

endmodule

// File: rtl/tlp_seq_ctrl.sv
`timescale 1ns/1ps
module tlp_seq_ctrl
   import tlp_req_pkg::*;
#(
   parameter int LEN_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [LEN_W:0]  ndw,
   input  logic            wr_pkt,
   input  logic            tx_ready,
   input  logic            wdat_valid,
   output sq_state_e       state,
   output logic            last_dw
);

   logic [LEN_W:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         rem_q <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (start) begin
               state <= SQ_HDR0;
               rem_q <= ndw;
            end
            SQ_HDR0: if (tx_ready) state <= SQ_HDR1;
            SQ_HDR1: if (tx_ready) state <= SQ_HDR2;
            SQ_HDR2: if (tx_ready) state <= wr_pkt ? SQ_DATA : SQ_IDLE;
            SQ_DATA: if (tx_ready && wdat_valid) begin
               rem_q <= rem_q - (LEN_W+1)'(1);
               if (rem_q == (LEN_W+1)'(1)) state <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign last_dw = (rem_q == (LEN_W+1)'(1));

endmodule

// File: rtl/tlp_tx_mux.sv
`timescale 1ns/1ps
module tlp_tx_mux
   import tlp_req_pkg::*;
(
   input  sq_state_e                       state,
   input  logic [HDR_DWORDS-1:0][DW_W-1:0] hdr_q,
   input  logic                            wr_q,
   input  logic                            last_dw,
   input  logic                            wdat_valid,
   input  logic [DW_W-1:0]                 wdat_data,
   input  logic                            tx_ready,
   output logic                            tx_valid,
   output logic [DW_W-1:0]                 tx_data,
   output logic                            tx_sop,
   output logic                            tx_eop,
   output logic                            wdat_ready
);

   logic [HDR_DWORDS-1:0]           hdr_sel;
   logic [HDR_DWORDS-1:0][DW_W-1:0] hdr_pick;
   logic                            in_data;

   genvar g;
   generate
      for (g = 0; g < HDR_DWORDS; g++) begin : g_hdr
         assign hdr_sel[g]  = (state == sq_state_e'(int'(SQ_HDR0) + g));
         assign hdr_pick[g] = hdr_sel[g] ? hdr_q[g] : '0;
      end
   endgenerate

   assign in_data = (state == SQ_DATA);

   always_comb begin
      tx_data = in_data ? wdat_data : '0;
      for (int i = 0; i < HDR_DWORDS; i++) tx_data = tx_data | hdr_pick[i];
   end

   assign tx_valid   = (|hdr_sel) | (in_data & wdat_valid);
   assign tx_sop     = hdr_sel[0];
   assign tx_eop     = (hdr_sel[HDR_DWORDS-1] & ~wr_q) | (in_data & last_dw);
   assign wdat_ready = in_data & tx_ready;

endmodule

// File: rtl/tlp_mem_req_builder.sv
`timescale 1ns/1ps
module tlp_mem_req_builder
   import tlp_req_pkg::*;
#(
   parameter int ID_W  = 16,
   parameter int TAG_W = 8,
   parameter int LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic             cmd_write,
   input  logic [ID_W-1:0]  cmd_req_id,
   input  logic [TAG_W-1:0] cmd_tag,
   input  logic [31:0]      cmd_addr,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             wdat_valid,
   output logic             wdat_ready,
   input  logic [31:0]      wdat_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [31:0]      tx_data,
   output logic             tx_sop,
   output logic             tx_eop
);

   localparam int MAX_DW = 1 << LEN_W;

   logic [HDR_DWORDS-1:0][DW_W-1:0] hdr_q;
   logic                            wr_q;
   logic                            start;
   logic [LEN_W:0]                  ndw;
   logic                            last_dw;
   sq_state_e                       state;

   assign cmd_ready = (state == SQ_IDLE);
   assign start     = cmd_valid & cmd_ready;
   assign ndw       = (cmd_len == '0) ? (LEN_W+1)'(MAX_DW) : {1'b0, cmd_len};

   tlp_hdr_reg #(.ID_W(ID_W), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_hdr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .wr     (cmd_write),
      .req_id (cmd_req_id),
      .tag    (cmd_tag),
      .addr   (cmd_addr),
      .len    (cmd_len),
      .hdr_q  (hdr_q),
      .wr_q   (wr_q)
   );

   tlp_seq_ctrl #(.LEN_W(LEN_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .ndw        (ndw),
      .wr_pkt     (wr_q),
      .tx_ready   (tx_ready),
      .wdat_valid (wdat_valid),
      .state      (state),
      .last_dw    (last_dw)
   );

   tlp_tx_mux u_mux (
      .state      (state),
      .hdr_q      (hdr_q),
      .wr_q       (wr_q),
      .last_dw    (last_dw),
      .wdat_valid (wdat_valid),
      .wdat_data  (wdat_data),
      .tx_ready   (tx_ready),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_sop     (tx_sop),
      .tx_eop     (tx_eop),
      .wdat_ready (wdat_ready)
   );

endmodule

// File: rtl/tlp_req_checker.sv
`timescale 1ns/1ps
module tlp_req_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic        cmd_ready,
   input logic        wdat_ready,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic [31:0] tx_data,
   input logic        tx_sop,
   input logic        tx_eop
);

   p_accept_sop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (tx_valid && tx_sop));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !tx_valid);

   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_eop) |=> cmd_ready);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=>
         (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

   p_wdat_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wdat_ready |-> (tx_ready && !tx_sop && !cmd_ready));

   p_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_sop) |->
         ((tx_data[31:24] == 8'h40 || tx_data[31:24] == 8'h00) && tx_data[23:10] == 14'd0));

   p_sop_not_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_sop) |-> !tx_eop);

endmodule

bind tlp_mem_req_builder tlp_req_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .wdat_ready (wdat_ready),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_data    (tx_data),
   .tx_sop     (tx_sop),
   .tx_eop     (tx_eop)
);

// File: tb/test_tlp_mem_req_builder.sv
`timescale 1ns/1ps
module test_tlp_mem_req_builder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_write = 1'b0;
   logic [15:0] cmd_req_id = '0;
   logic [7:0]  cmd_tag = '0;
   logic [31:0] cmd_addr = '0;
   logic [9:0]  cmd_len = '0;
   logic        wdat_valid = 1'b0;
   logic        wdat_ready;
   logic [31:0] wdat_data = '0;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [31:0] tx_data;
   logic        tx_sop;
   logic        tx_eop;

   int          total = 0;
   int          bad = 0;
   int          cyc = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   tlp_mem_req_builder i_tlp_mem_req_builder (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_req_id(cmd_req_id), .cmd_tag(cmd_tag), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_sop(tx_sop), .tx_eop(tx_eop)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pay(input int seed, input int j);
      return 32'h9E3779B9 * 32'(seed) + 32'h00010003 * 32'(j);
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic run_pkt(input bit wr, input logic [15:0] id, input logic [7:0] tag,
                          input logic [31:0] addr, input logic [9:0] len,
                          input int mode, input int seed);
      int          n;
      int          tot;
      int          idx;
      bit          first;
      bit          wv;
      bit          rdy;
      logic [31:0] h0, h1, h2, exp_d;
      string       lbl;
      n   = (len == 0) ? 1024 : int'(len);
      tot = wr ? n + 3 : 3;
      h0  = {(wr ? 8'h40 : 8'h00), 14'd0, len};
      h1  = {id, tag, ((n == 1) ? 4'h0 : 4'hF), 4'hF};
      h2  = {addr[31:2], 2'b00};
      cmd_valid = 1'b1; cmd_write = wr; cmd_req_id = id; cmd_tag = tag;
      cmd_addr = addr; cmd_len = len; tx_ready = 1'b0; wdat_valid = 1'b0;
      #1;
      chk(cmd_ready == 1'b1, "R2 ready when idle", 32'(cmd_ready), 32'd1);
      @(negedge clk);
      // busy: scrambled command must be ignored (R2)
      cmd_write = ~wr; cmd_req_id = ~id; cmd_tag = ~tag; cmd_addr = ~addr; cmd_len = len ^ 10'h155;
      idx = 0; first = 1'b1; wv = 1'b0;
      while (idx < tot) begin
         step_lfsr();
         case (mode)
            0:       rdy = 1'b1;
            1:       rdy = lfsr[0] | lfsr[3];
            default: rdy = lfsr[1] & lfsr[7];
         endcase
         tx_ready = rdy;
         if (idx >= 3) begin
            if (!wv) begin
               case (mode)
                  0:       wv = 1'b1;
                  1:       wv = lfsr[5];
                  default: wv = lfsr[2] | lfsr[4];
               endcase
            end
            wdat_valid = wv;
            wdat_data  = pay(seed, idx - 3);
         end else begin
            wdat_valid = lfsr[9];
            wdat_data  = {lfsr, ~lfsr};
         end
         #1;
         if (first) chk(tx_valid && tx_sop, "R10 sop after accept", {30'd0, tx_valid, tx_sop}, 32'd3);
         first = 1'b0;
         chk(cmd_ready == 1'b0, "R2 busy", 32'(cmd_ready), 32'd0);
         if (wr) chk(wdat_ready == ((idx >= 3) && rdy), "R6 wdat_ready", 32'(wdat_ready), 32'((idx >= 3) && rdy));
         else    chk(wdat_ready == 1'b0, "R7 no payload pull", 32'(wdat_ready), 32'd0);
         if (idx >= 3) chk(tx_valid == wv, "R9 valid follows payload", 32'(tx_valid), 32'(wv));
         else          chk(tx_valid == 1'b1, "R9 header valid", 32'(tx_valid), 32'd1);
         if (tx_valid) begin
            case (idx)
               0: begin exp_d = h0; lbl = "R3 dword0"; end
               1: begin exp_d = h1; lbl = "R4 dword1"; end
               2: begin exp_d = h2; lbl = "R5 dword2"; end
               default: begin exp_d = pay(seed, idx - 3); lbl = "R6 payload"; end
            endcase
            chk(tx_data == exp_d, lbl, tx_data, exp_d);
            chk(tx_sop == (idx == 0), "R8 sop", 32'(tx_sop), 32'(idx == 0));
            chk(tx_eop == (idx == tot - 1), wr ? "R8 eop" : "R7 eop", 32'(tx_eop), 32'(idx == tot - 1));
            if (rdy) begin
               idx++;
               wv = 1'b0;
            end
         end
         @(negedge clk);
      end
      cmd_valid = 1'b0; tx_ready = 1'b0; wdat_valid = 1'b0;
      #1;
      chk(cmd_ready == 1'b1, "R2 ready after eop", 32'(cmd_ready), 32'd1);
      chk(tx_valid == 1'b0, "R2 quiet after eop", 32'(tx_valid), 32'd0);
      @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      int seed;
      logic [9:0] lens [5];
      lens[0] = 10'd1; lens[1] = 10'd2; lens[2] = 10'd3; lens[3] = 10'd7; lens[4] = 10'd0;
      repeat (3) @(negedge clk);
      #1;
      chk(cmd_ready == 1'b1, "R1 ready in reset", 32'(cmd_ready), 32'd1);
      chk(tx_valid == 1'b0, "R1 idle in reset", 32'(tx_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 32'd1);
      chk(tx_valid == 1'b0, "R1 idle after reset", 32'(tx_valid), 32'd0);
      @(negedge clk);
      seed = 1;
      for (int w = 0; w < 2; w++) begin
         for (int li = 0; li < 5; li++) begin
            for (int m = 0; m < 3; m++) begin
               run_pkt(w[0], 16'h0100 * 16'(seed) + 16'h0011, 8'(seed * 7 + 8'h1F),
                       32'h4000_0100 + 32'(li * 4) + 32'(m) , lens[li], m, seed);
               seed++;
            end
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule